// File: doc/BRIEF.md
# Selectable-Source Watchdog Timer

This block is a watchdog time base that runs on one system clock. Its count source is picked from three options by a fixed option input: a tick made inside the block once every four system clock cycles, a single-cycle tick from a real-time-clock domain, or a single-cycle tick from a dedicated watchdog oscillator. Both external ticks arrive already synchronised to the system clock.

The selected ticks advance an 8-bit prescaler. A 3-bit period select picks one prescaler bit. Each carry out of that bit, which is the bit's falling edge, is turned into a clock-enable for a 7-bit counter. When the 7-bit counter wraps, the block raises a one-cycle time-out pulse and keeps counting. Software keeps the watchdog from expiring by pulsing the clear strobe. The clear zeroes the whole chain.

Top module: `sel_src_watchdog`

## Requirements
- R1: The source option selects the count source. Code 2'b00 selects the internal divide-by-four tick, 2'b01 selects `rtc_tick_i`, and both 2'b10 and 2'b11 select `wdo_tick_i`. A tick on an input that is not selected has no effect on `cnt_o` or `tmo_o`.
- R2: With code 2'b00, a source tick occurs on every fourth clock edge after a clear, so 4·K clock cycles give K ticks. Two source ticks never occur on consecutive cycles.
- R3: With period select n (0 to 7), `cnt_o` advances by one each time prescaler bit n goes from 1 to 0, which is once every 2^(n+1) source ticks counted from a clear. The new value appears on `cnt_o` one clock edge after the edge that took in the tick.
- R4: When the 7-bit counter steps from 127 to 0, `tmo_o` is high for exactly one cycle, in the same cycle in which `cnt_o` reads 0. This happens every 128·2^(n+1) source ticks after a clear, and counting goes on without a pause.
- R5: A cycle with `clr_i` high sets the divider, the prescaler and the 7-bit counter to zero. A time-out that would have fired on that edge is dropped, so `tmo_o` stays low.
- R6: A change of `period_sel_i` never advances `cnt_o` by itself. After a change, only a 1-to-0 transition of the newly selected prescaler bit counts.
- R7: While `rst_n` is low, `cnt_o` is 0 and `tmo_o` is 0.
- R8: `cnt_o` holds its value on every edge at which the selected prescaler bit has no 1-to-0 transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_opt_i | input | 2 | Static count-source option (see R1) |
| rtc_tick_i | input | 1 | Single-cycle tick from the real-time-clock domain |
| wdo_tick_i | input | 1 | Single-cycle tick from the watchdog oscillator |
| period_sel_i | input | 3 | Prescaler bit that feeds the 7-bit counter |
| clr_i | input | 1 | Software clear strobe |
| tmo_o | output | 1 | One-cycle time-out pulse |
| cnt_o | output | 7 | Current 7-bit counter value |

## Verification
Ticks are run on each source in turn and on the source that is not selected, so a wrong source decode shows up as a count that is off or zero. Tick counts sit just below, at, and beyond a counter wrap for several period selects, which separates an off-by-one tap or edge polarity error from a correct period. Directed cases then do three things: clear while a wrap is pending, clear while prescaler bit 0 is set, and switch the select away from a tap that is high. These tell apart a full clear from a partial one, and a re-armed edge detector from one that counts the switch.

// File: rtl/sswd_pkg.sv
package sswd_pkg;

   // Count-source option codes; the two upper codes both mean the watchdog oscillator.
   typedef enum logic [1:0] {
      SRC_SYS4    = 2'b00,
      SRC_RTC     = 2'b01,
      SRC_WDO     = 2'b10,
      SRC_WDO_ALT = 2'b11
   } src_e;

   localparam int DEF_PRE_W    = 8;
   localparam int DEF_CNT_W    = 7;
   localparam int DEF_SEL_W    = 3;
   localparam int DEF_DIV_LOG2 = 2;

endpackage

// File: rtl/sswd_tick_src.sv
module sswd_tick_src
   import sswd_pkg::*;
#(
   parameter int DIV_LOG2 = DEF_DIV_LOG2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic [1:0] src_i,
   input  logic       rtc_tick_i,
   input  logic       wdo_tick_i,
   output logic       tick_o
);

   logic sys_tick;

   generate
      if (DIV_LOG2 < 0) begin : g_bad_div
         $error("sswd_tick_src: DIV_LOG2 must not be negative");
      end

      if (DIV_LOG2 == 0) begin : g_no_div
         assign sys_tick = 1'b1;
      end else begin : g_div
         logic [DIV_LOG2-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     div_q <= '0;
            else if (clr_i) div_q <= '0;
            else            div_q <= div_q + 1'b1;
         end

         assign sys_tick = &div_q;

         // The divided tick is never high on back-to-back cycles
         AST_SYS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            (src_i == SRC_SYS4 && tick_o) |=> !(src_i == SRC_SYS4 && tick_o)); // R2
      end
   endgenerate

   always_comb begin
      case (src_e'(src_i))
         SRC_SYS4:             tick_o = sys_tick;
         SRC_RTC:              tick_o = rtc_tick_i;
         SRC_WDO, SRC_WDO_ALT: tick_o = wdo_tick_i;
         default:              tick_o = wdo_tick_i;
      endcase
   end

endmodule

// File: rtl/sswd_prescaler.sv
module sswd_prescaler
   import sswd_pkg::*;
#(
   parameter int PRE_W = DEF_PRE_W,
   parameter int SEL_W = DEF_SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             step_o
);

   localparam int N_TAPS = 1 << SEL_W;

   generate
      if (N_TAPS > PRE_W) begin : g_bad_taps
         $error("sswd_prescaler: select reaches past the prescaler width");
      end
   endgenerate

   logic [PRE_W-1:0]  pre_q;
   logic [N_TAPS-1:0] tap_vec;
   logic [SEL_W-1:0]  sel_q;
   logic              tap_prev_q;
   logic              tap;
   logic              sel_chg;

   genvar gi;
   generate
      for (gi = 0; gi < N_TAPS; gi++) begin : g_tap
         assign tap_vec[gi] = pre_q[gi];
      end
   endgenerate

   assign tap     = tap_vec[sel_i];
   assign sel_chg = (sel_i != sel_q);
   // carry out of the chosen stage: it was 1 and is now 0, with no select change in between
   assign step_o  = tap_prev_q & ~tap & ~sel_chg & ~clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q      <= '0;
         tap_prev_q <= 1'b0;
         sel_q      <= '0;
      end else if (clr_i) begin
         pre_q      <= '0;
         tap_prev_q <= 1'b0;
         sel_q      <= sel_i;
      end else begin
         if (tick_i) pre_q <= pre_q + 1'b1;
         tap_prev_q <= tap;
         sel_q      <= sel_i;
      end
   end

   AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (pre_q == '0)); // R5
   AST_NO_DOUBLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |=> !step_o); // R3
   AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clr_i) |=> $stable(pre_q)); // R3

endmodule

// File: rtl/sswd_stage_cnt.sv
module sswd_stage_cnt
   import sswd_pkg::*;
#(
   parameter int CNT_W = DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             tmo_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("sswd_stage_cnt: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             tmo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tmo_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q <= '0;
         tmo_q <= 1'b0;
      end else begin
         tmo_q <= step_i && (cnt_q == CNT_MAX);
         if (step_i) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign tmo_o = tmo_q;

   AST_TMO_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q |-> (cnt_q == '0)); // R4
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0 && !tmo_q)); // R5
   AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !clr_i) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/sel_src_watchdog.sv
module sel_src_watchdog
   import sswd_pkg::*;
#(
   parameter int PRE_W    = DEF_PRE_W,
   parameter int CNT_W    = DEF_CNT_W,
   parameter int SEL_W    = DEF_SEL_W,
   parameter int DIV_LOG2 = DEF_DIV_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       src_opt_i,
   input  logic             rtc_tick_i,
   input  logic             wdo_tick_i,
   input  logic [SEL_W-1:0] period_sel_i,
   input  logic             clr_i,
   output logic             tmo_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic src_tick;
   logic step;

   sswd_tick_src #(.DIV_LOG2(DIV_LOG2)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr_i),
      .src_i      (src_opt_i),
      .rtc_tick_i (rtc_tick_i),
      .wdo_tick_i (wdo_tick_i),
      .tick_o     (src_tick)
   );

   sswd_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_i),
      .tick_i (src_tick),
      .sel_i  (period_sel_i),
      .step_o (step)
   );

   sswd_stage_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_i),
      .step_i (step),
      .cnt_o  (cnt_o),
      .tmo_o  (tmo_o)
   );

   AST_TMO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_o |=> !tmo_o); // R4
   AST_RESET_QUIET: assert property (@(negedge clk)
      !rst_n |-> (cnt_o == '0 && !tmo_o)); // R7

endmodule

// File: tb/sel_src_watchdog_tb_top.sv
`timescale 1ns/1ps
module sel_src_watchdog_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] src_opt = 2'b01;
   logic       rtc_tick = 1'b0;
   logic       wdo_tick = 1'b0;
   logic [2:0] psel = 3'd0;
   logic       clr = 1'b0;
   logic       tmo;
   logic [6:0] cnt;

   int total = 0;
   int bad = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sel_src_watchdog dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_opt_i    (src_opt),
      .rtc_tick_i   (rtc_tick),
      .wdo_tick_i   (wdo_tick),
      .period_sel_i (psel),
      .clr_i        (clr),
      .tmo_o        (tmo),
      .cnt_o        (cnt)
   );

   // {src[2], sel[3], drive[2], cycles[16], exp_cnt[7], exp_pulses[2], tag[2]}
   // drive: bit0 -> rtc_tick_i, bit1 -> wdo_tick_i (held high every cycle)
   // tag: 0 R3 period path, 1 R1 source decode, 2 R2 divided tick
   localparam logic [33:0] VEC [15] = '{
      {2'd1, 3'd0, 2'd1, 16'd1,    7'd0,   2'd0, 2'd0},
      {2'd1, 3'd0, 2'd1, 16'd2,    7'd1,   2'd0, 2'd0},
      {2'd1, 3'd0, 2'd1, 16'd255,  7'd127, 2'd0, 2'd0},
      {2'd1, 3'd0, 2'd1, 16'd256,  7'd0,   2'd1, 2'd0},
      {2'd1, 3'd3, 2'd1, 16'd80,   7'd5,   2'd0, 2'd0},
      {2'd1, 3'd7, 2'd1, 16'd768,  7'd3,   2'd0, 2'd0},
      {2'd2, 3'd1, 2'd2, 16'd512,  7'd0,   2'd1, 2'd1},
      {2'd2, 3'd2, 2'd2, 16'd1040, 7'd2,   2'd1, 2'd1},
      {2'd0, 3'd0, 2'd0, 16'd40,   7'd5,   2'd0, 2'd2},
      {2'd0, 3'd1, 2'd0, 16'd2048, 7'd0,   2'd1, 2'd2},
      {2'd3, 3'd0, 2'd2, 16'd6,    7'd3,   2'd0, 2'd1},
      {2'd1, 3'd0, 2'd2, 16'd50,   7'd0,   2'd0, 2'd1},
      {2'd2, 3'd0, 2'd1, 16'd50,   7'd0,   2'd0, 2'd1},
      {2'd0, 3'd0, 2'd3, 16'd40,   7'd5,   2'd0, 2'd2},
      {2'd1, 3'd0, 2'd1, 16'd768,  7'd0,   2'd3, 2'd0}
   };

   function automatic string tag_name(input logic [1:0] t);
      case (t)
         2'd1:    return "R1";
         2'd2:    return "R2";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // advance one cycle; outputs sampled at the falling edge
   task automatic cyc();
      @(negedge clk);
      if (tmo) pulses++;
   endtask

   task automatic do_clear();
      clr = 1'b1;
      cyc();
      clr = 1'b0;
      pulses = 0;
   endtask

   task automatic run(input logic [1:0] drv, input int n);
      for (int i = 0; i < n; i++) begin
         rtc_tick = drv[0];
         wdo_tick = drv[1];
         cyc();
      end
      rtc_tick = 1'b0;
      wdo_tick = 1'b0;
      cyc();
      cyc();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R7: outputs quiet during reset
      repeat (3) @(negedge clk);
      chk("R7 cnt in reset", int'(cnt), 0);
      chk("R7 tmo in reset", int'(tmo), 0);
      rst_n = 1'b1;
      cyc();

      // table walk: R1 R2 R3 R4
      for (int v = 0; v < 15; v++) begin
         src_opt = VEC[v][33:32];
         psel    = VEC[v][31:29];
         do_clear();
         run(VEC[v][28:27], int'(VEC[v][26:11]));
         chk($sformatf("%s cnt vec%0d", tag_name(VEC[v][1:0]), v), int'(cnt), int'(VEC[v][10:4]));
         chk($sformatf("R4 pulses vec%0d", v), pulses, int'(VEC[v][3:2]));
      end

      // R5: clear while prescaler bit 0 is set leaves no stale carry
      src_opt = 2'b01;
      psel = 3'd0;
      do_clear();
      run(2'b01, 101);
      chk("R3 cnt before clear", int'(cnt), 50);
      do_clear();
      chk("R5 cnt after clear", int'(cnt), 0);
      run(2'b01, 1);
      chk("R5 prescaler cleared", int'(cnt), 0);

      // R5: clear on the edge where a wrap is pending suppresses the time-out
      do_clear();
      for (int i = 0; i < 256; i++) begin
         rtc_tick = 1'b1;
         cyc();
      end
      rtc_tick = 1'b0;
      clr = 1'b1;
      cyc();
      clr = 1'b0;
      cyc();
      cyc();
      chk("R5 no tmo on clear", pulses, 0);
      chk("R5 cnt zero", int'(cnt), 0);

      // R6: switch select away from a tap that is high
      psel = 3'd0;
      do_clear();
      run(2'b01, 1);
      chk("R3 one tick no step", int'(cnt), 0);
      psel = 3'd3;
      cyc();
      cyc();
      chk("R6 no step on select change", int'(cnt), 0);
      run(2'b01, 15);
      chk("R6 counts new tap", int'(cnt), 1);

      // R8: no ticks, value holds
      run(2'b00, 20);
      chk("R8 hold without ticks", int'(cnt), 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule